// File: doc/BRIEF.md
# UART-Framed 1-Wire Bus Master

This block drives a single open-drain 1-Wire line by shaping each bus slot as one asynchronous serial frame: a low start cell, eight data cells sent least significant bit first, and a high stop cell. Each operation chooses two things: a bit-cell length, either slow for the reset/presence slot or fast for data slots, and a fixed pattern byte. These decide how long the master holds the wire low. The same line is sampled in the middle of every cell while the frame goes out. The echoed byte therefore shows any device pulling the wire low, and the block decodes it into a presence flag or a read bit.

A host issues one operation at a time through a small command port and watches `busy`. The block returns a one-clock `done` strobe with `result` and `frame_err`. Both outputs stay valid until the next `done`. Both cell lengths are computed from the system clock frequency at elaboration. The rate is latched only when a command is accepted, so it can change only between frames.

The controller has four states. `ST_IDLE` waits for a command. `ST_START` drives the start cell. `ST_DATA` sends and samples the eight data cells. `ST_STOP` releases the line and samples the stop cell. The transitions are: IDLE to START on an accepted command; START to DATA at the end of the start cell; DATA to STOP at the end of the eighth data cell; STOP to IDLE at the end of the stop cell, which also issues `done`.

Top module: `owire_uart_master`

## Requirements
- R1: After reset, `busy`, `done`, `line_oe`, `result` and `frame_err` are all 0.
- R2: Op code 0 (bus reset) transmits pattern 0xF0 with a slow cell of round(CLK_HZ/9600) clocks. `line_oe` is high for exactly 5 slow cells (the start cell plus four zero data bits).
- R3: For op code 0, `result` is 1 when the echoed byte differs from 0xF0 (a device answered) and 0 when it equals 0xF0.
- R4: Op code 1 (write zero) transmits 0x80 with a fast cell of round(CLK_HZ/115200) clocks. `line_oe` is high for exactly 8 fast cells.
- R5: Op codes 2 (write one) and 3 (read bit) transmit 0xFF. `line_oe` is high for exactly one fast cell.
- R6: For op code 3, `result` is 1 when the echoed byte is 0xFF and 0 otherwise.
- R7: For op codes 1 and 2, `result` is 0.
- R8: `frame_err` is 1 at `done` when the line was low at the middle of the stop cell, and 0 otherwise.
- R9: `cmd_valid` and `cmd_op` are ignored while `busy` is high. Such a command starts no frame and produces no `done`.
- R10: `done` is high for exactly one clock per frame. `result` and `frame_err` change only with `done` and stay unchanged until the next `done`.
- R11: `busy` rises on the clock that accepts a command and falls with `done`. `line_oe` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request, taken when `busy` is low |
| cmd_op | input | 2 | Operation: 0 reset, 1 write zero, 2 write one, 3 read bit |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-clock strobe at the end of a frame |
| result | output | 1 | Presence flag (op 0) or read bit (op 3); 0 for writes |
| frame_err | output | 1 | Stop cell was seen low |
| line_oe | output | 1 | Pull the open-drain line low when 1 |
| line_in | input | 1 | Sampled level of the wire |

## Verification
The end of a frame and the start of the next one meet on the same clock edge. The host holds `cmd_valid` high while the previous frame is still running, with a wrong op code in place during that time. It switches to the real op code only in the cycle where `done` is high and `busy` has dropped. The scoreboard then expects exactly one `done` per intended command. It expects the new frame's low time to match the new op and its rate, and the previous result to stay held until the next strobe. A bogus frame started during `busy`, or a rate that did not switch between a slow reset and a fast slot, both show up as a wrong low-time count or an unexpected `done`.

// File: rtl/owm_pkg.sv
package owm_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_WR0   = 2'd1,
        OP_WR1   = 2'd2,
        OP_READ  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } state_e;

    localparam logic [7:0] PAT_RESET = 8'hF0;
    localparam logic [7:0] PAT_ZERO  = 8'h80;
    localparam logic [7:0] PAT_ONE   = 8'hFF;

    function automatic logic [7:0] pattern_of(input op_e op);
        logic [7:0] p;
        unique case (op)
            OP_RESET: p = PAT_RESET;
            OP_WR0:   p = PAT_ZERO;
            default:  p = PAT_ONE;
        endcase
        return p;
    endfunction

    function automatic logic decode_of(input op_e op, input logic [7:0] echo);
        logic r;
        unique case (op)
            OP_RESET: r = (echo != PAT_RESET);
            OP_READ:  r = (echo == PAT_ONE);
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/owm_cell_timer.sv
module owm_cell_timer #(
    parameter int SLOW_DIV = 208,
    parameter int FAST_DIV = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow,
    output logic mid,
    output logic last
);
    localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int CW      = $clog2(MAX_DIV + 1);
    localparam logic [CW-1:0] SLOW_END = CW'(SLOW_DIV - 1);
    localparam logic [CW-1:0] FAST_END = CW'(FAST_DIV - 1);
    localparam logic [CW-1:0] SLOW_MID = CW'(SLOW_DIV / 2);
    localparam logic [CW-1:0] FAST_MID = CW'(FAST_DIV / 2);

    logic [CW-1:0] cnt;
    logic [CW-1:0] end_val;
    logic [CW-1:0] mid_val;

    always_comb begin
        end_val = slow ? SLOW_END : FAST_END;
        mid_val = slow ? SLOW_MID : FAST_MID;
        last    = run && (cnt == end_val);
        mid     = run && (cnt == mid_val);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/owm_line_sync.sv
module owm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '1;
                else        q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '1;
                else        q <= {q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/owm_shift8.sv
module owm_shift8 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       shift,
    input  logic       shift_in,
    output logic [7:0] value
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= 8'hFF;
        end else if (load) begin
            value <= load_val;
        end else if (shift) begin
            value <= {shift_in, value[7:1]};
        end
    end
endmodule

// File: rtl/owire_uart_master.sv
module owire_uart_master
    import owm_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int SLOW_BAUD   = 9600,
    parameter int FAST_BAUD   = 115200,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    output logic       busy,
    output logic       done,
    output logic       result,
    output logic       frame_err,
    output logic       line_oe,
    input  logic       line_in
);
    localparam int SLOW_DIV = (CLK_HZ + SLOW_BAUD / 2) / SLOW_BAUD;
    localparam int FAST_DIV = (CLK_HZ + FAST_BAUD / 2) / FAST_BAUD;

    state_e     state, state_nx;
    op_e        op_q;
    logic       slow_q;
    logic [2:0] bit_idx;
    logic       stop_ok;
    logic       accept;
    logic       cell_mid, cell_last;
    logic       line_s;
    logic [7:0] tx_val, rx_val;

    assign accept = (state == ST_IDLE) && cmd_valid;

    owm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(line_in), .dout(line_s)
    );

    owm_cell_timer #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state != ST_IDLE), .slow(slow_q),
        .mid(cell_mid), .last(cell_last)
    );

    owm_shift8 u_tx (
        .clk(clk), .rst_n(rst_n),
        .load(accept), .load_val(pattern_of(op_e'(cmd_op))),
        .shift((state == ST_DATA) && cell_last), .shift_in(1'b1),
        .value(tx_val)
    );

    owm_shift8 u_rx (
        .clk(clk), .rst_n(rst_n),
        .load(1'b0), .load_val(8'h00),
        .shift((state == ST_DATA) && cell_mid), .shift_in(line_s),
        .value(rx_val)
    );

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cmd_valid) state_nx = ST_START;
            ST_START: if (cell_last) state_nx = ST_DATA;
            ST_DATA:  if (cell_last && bit_idx == 3'd7) state_nx = ST_STOP;
            ST_STOP:  if (cell_last) state_nx = ST_IDLE;
        endcase
    end

    // state register and per-frame context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            op_q    <= OP_RESET;
            slow_q  <= 1'b0;
            bit_idx <= '0;
            stop_ok <= 1'b1;
        end else begin
            state <= state_nx;
            if (accept) begin
                op_q    <= op_e'(cmd_op);
                slow_q  <= (op_e'(cmd_op) == OP_RESET);
                bit_idx <= '0;
            end else if ((state == ST_DATA) && cell_last) begin
                bit_idx <= bit_idx + 1'b1;
            end
            if ((state == ST_STOP) && cell_mid) begin
                stop_ok <= line_s;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            result    <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            done <= 1'b0;
            if ((state == ST_STOP) && cell_last) begin
                done      <= 1'b1;
                result    <= decode_of(op_q, rx_val);
                frame_err <= !stop_ok;
            end
        end
    end

    // line drive and busy
    always_comb begin
        busy = (state != ST_IDLE);
        unique case (state)
            ST_START: line_oe = 1'b1;
            ST_DATA:  line_oe = !tx_val[0];
            default:  line_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/owm_checker.sv
module owm_checker (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic result,
    input logic frame_err,
    input logic line_oe
);
    // R11: line released whenever no frame runs
    p_oe_in_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !line_oe);

    // R11: a frame starts only from a request
    p_start_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

    // R10: strobe lasts one clock
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: done ends a frame
    p_done_ends_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R10: results held between strobes
    p_result_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(frame_err)));

    // R9: no restart without an idle cycle
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));
endmodule

bind owire_uart_master owm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
    .done(done), .result(result), .frame_err(frame_err), .line_oe(line_oe)
);

// File: tb/owire_uart_master_test.sv
`timescale 1ns/1ps
module owire_uart_master_test;
    // 2 MHz nominal clock for the divider math keeps frames short.
    localparam int T_SLOW = 208;  // round(2e6/9600)
    localparam int T_FAST = 17;   // round(2e6/115200)

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic       busy, done, result, frame_err, line_oe;
    logic       dev_pull = 1'b0;
    logic       line_in;

    assign line_in = !(line_oe || dev_pull);

    owire_uart_master #(.CLK_HZ(2_000_000)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .busy(busy), .done(done), .result(result), .frame_err(frame_err),
        .line_oe(line_oe), .line_in(line_in)
    );

    always #2.5 clk = !clk;

    typedef struct {
        int op;
        bit res;
        bit err;
        int low;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int next_lo = 99, next_hi = 0, next_div = T_FAST;
    bit running = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Driver: request is raised early with a wrong op while busy (R9),
    // then the real op is placed only when busy is low.
    task automatic issue(input int op, input int lo, input int hi,
                         input bit eres, input bit eerr);
        exp_t e;
        e.op  = op;
        e.res = eres;
        e.err = eerr;
        e.low = (op == 0) ? 5 * T_SLOW : (op == 1) ? 8 * T_FAST : T_FAST;
        exp_q.push_back(e);
        cmd_valid = 1'b1;
        cmd_op    = 2'(op ^ 1);
        while (busy) @(negedge clk);
        cmd_op   = 2'(op);
        next_lo  = lo;
        next_hi  = hi;
        next_div = (op == 0) ? T_SLOW : T_FAST;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Device model and monitor
    int  k = 0, lo = 99, hi = 0, dv = T_FAST;
    bit  busy_prev = 1'b0, done_prev = 1'b0;
    int  low_cnt = 0;
    bit  have_held = 1'b0, held_res = 1'b0, held_err = 1'b0, held_ok = 1'b1;

    always @(negedge clk) begin
        if (running) begin
            cycles++;
            if (busy && !busy_prev) begin
                k = 0; lo = next_lo; hi = next_hi; dv = next_div;
            end else if (busy) begin
                k++;
            end
            dev_pull = busy && (k >= lo * dv) && (k < (hi + 1) * dv);
            busy_prev = busy;

            if (line_oe) low_cnt++;
            if (!busy && line_oe) check(1'b0, "R11", "line_oe while idle", 1, 0);
            if (done_prev) check(!done, "R10", "done width", done, 0);
            if (!done && have_held && (result != held_res || frame_err != held_err))
                held_ok = 1'b0;

            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    string rq;
                    e = exp_q.pop_front();
                    // R3 presence, R6 read bit, R7 writes give 0
                    rq = (e.op == 0) ? "R3" : (e.op == 3) ? "R6" : "R7";
                    check(result == e.res, rq, "result", result, e.res);
                    check(frame_err == e.err, "R8", "frame_err", frame_err, e.err);
                    rq = (e.op == 0) ? "R2" : (e.op == 1) ? "R4" : "R5";
                    check(low_cnt == e.low, rq, "low cycles", low_cnt, e.low);
                    check(held_ok, "R10", "result held", 0, 1);
                    check(!busy, "R11", "busy at done", busy, 0);
                end
                low_cnt   = 0;
                have_held = 1'b1;
                held_res  = result;
                held_err  = frame_err;
                held_ok   = 1'b1;
            end
            done_prev = done;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy && !done && !line_oe && !result && !frame_err, "R1",
              "reset outputs", {busy, done, line_oe, result, frame_err}, 0);
        running = 1'b1;

        issue(0, 99, 0, 1'b0, 1'b0);  // R3 no device: echo 0xF0
        issue(0, 6, 7, 1'b1, 1'b0);   // R3 presence pulse in cells 6..7
        issue(1, 99, 0, 1'b0, 1'b0);  // R4 write zero, rate switches fast
        issue(2, 99, 0, 1'b0, 1'b0);  // R5 write one
        issue(3, 99, 0, 1'b1, 1'b0);  // R6 read one
        issue(3, 1, 3, 1'b0, 1'b0);   // R6 read zero
        issue(3, 8, 8, 1'b0, 1'b0);   // R6 only bit7 low: 0x7F
        issue(3, 9, 9, 1'b1, 1'b1);   // R8 stop cell held low
        issue(0, 9, 9, 1'b0, 1'b1);   // R8 on slow rate, no presence
        issue(2, 99, 0, 1'b0, 1'b0);  // R7 write after slow reset

        while ((exp_q.size() != 0 || busy) && cycles < 150000) @(negedge clk);
        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, "R9", "pending frames", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #900000;
        checks++;
        errors++;
        $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule